// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block guards a system against software that has stopped making progress. A down-counter advances on a slow tick-enable input. When it runs out, the block raises a one-cycle reset request. Software must keep refreshing the counter to prevent this. All control goes through one 32-bit control word, which carries three things: a reload count, a start/stop command bit and a 7-bit key.

While the stored command bit is set, a new control write is honoured only if its key is the bitwise inverse of the key in the stored word. Legitimate refreshes therefore alternate between a key and its complement. A stray or runaway write is very unlikely to keep the watchdog alive or to switch it off. While the stored command bit is clear, any key is taken. A status word reports the remaining count and whether the counter is running.

Top module: `wdg_guard`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0 (count 0, not running) and `rst_req` is low.
- R2: The control word sits at byte offset 0x40. Its fields are: count in bits [7:0], command in bit 8, key in bits [15:9]. An accepted write stores the whole 32-bit word, and the control offset reads it back unchanged.
- R3: While the stored bit 8 is 0, a control write is accepted whatever its key.
- R4: While the stored bit 8 is 1, a control write whose key is not the bitwise complement of stored bits [15:9] has no effect on the control word, the count or the running state.
- R5: An accepted write loads the counter from bits [7:0]. A value of 0 loads 256.
- R6: An accepted write with bit 8 = 1 starts the counter, or restarts it if it is already running. An accepted write with bit 8 = 0 stops it at the loaded value, and ticks then leave the count unchanged.
- R7: While the counter runs, it drops by exactly one on each cycle with `tick_en` high, and it holds on cycles without a tick.
- R8: The tick that takes the count from 1 to 0 raises `rst_req` for exactly one cycle, starting at the same edge. The counter then stays at 0 and stopped until the next accepted start write. The stored key protection stays in force.
- R9: The status word at offset 0x44 holds the count in bits [8:0] and the running flag in bit 9, with all other bits 0. Reads of any other offset return 0, and writes to other offsets change nothing.
- R10: If an accepted control write and a tick fall in the same cycle, the write wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Slow time-base enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read (combinational read) |
| rd_data | output | 32 | Read data |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The key gate is exercised with several write patterns:
- a first write while disabled, which separates "any key" acceptance from a design that always demands a complement;
- a repeated identical key, which must be rejected;
- a correct complement, which must be taken;
- a stop write, which clears protection so that an unrelated key is accepted next.

The counter is then run down from a small reload until it expires. This shows that the reset pulse coincides with count 0, lasts a single cycle, and is followed by a frozen counter. A zero reload checks the 256 substitution. A write coinciding with a tick checks that the write has priority.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int WD_DATA_W   = 32;
  localparam int WD_CNT_W    = 8;
  localparam int WD_KEY_W    = 7;
  localparam int WD_CMD_BIT  = WD_CNT_W;
  localparam int WD_KEY_LSB  = WD_CNT_W + 1;
  localparam int WD_KEY_MSB  = WD_KEY_LSB + WD_KEY_W - 1;
  localparam int WD_VAL_W    = WD_CNT_W + 1;
  localparam int WD_RUN_BIT  = WD_VAL_W;
  localparam int WD_RELOAD_Z = 1 << WD_CNT_W;

  function automatic logic [WD_DATA_W-1:0] pack_status(
    input logic [WD_VAL_W-1:0] val,
    input logic                run
  );
    logic [WD_DATA_W-1:0] w;
    w = '0;
    w[WD_VAL_W-1:0] = val;
    w[WD_RUN_BIT]   = run;
    return w;
  endfunction
endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate
  import wdg_pkg::*;
(
  input  logic                 wr_ctrl,
  input  logic [WD_DATA_W-1:0] wr_data,
  input  logic [WD_DATA_W-1:0] ctrl_q,
  output logic                 accept
);
  logic                locked;
  logic [WD_KEY_W-1:0] want_key;
  logic [WD_KEY_W-1:0] got_key;

  always_comb begin
    locked   = ctrl_q[WD_CMD_BIT];
    want_key = ~ctrl_q[WD_KEY_MSB:WD_KEY_LSB];
    got_key  = wr_data[WD_KEY_MSB:WD_KEY_LSB];
    accept   = wr_ctrl && (!locked || (got_key == want_key));
  end
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [WD_DATA_W-1:0] wr_data,
  output logic [WD_DATA_W-1:0] ctrl_q
);
  logic [WD_DATA_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (accept) ctrl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2
  store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ctrl_q == $past(wr_data));
endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt
  import wdg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                accept,
  input  logic [WD_CNT_W-1:0] ld_val,
  input  logic                ld_run,
  output logic [WD_VAL_W-1:0] cnt_q,
  output logic                run_q,
  output logic                rst_req
);
  logic [WD_VAL_W-1:0] cnt_d;
  logic                run_d;
  logic                req_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    req_d = 1'b0;
    if (accept) begin
      cnt_d = (ld_val == '0) ? WD_VAL_W'(WD_RELOAD_Z) : {1'b0, ld_val};
      run_d = ld_run;
    end else if (run_q && tick_en) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == WD_VAL_W'(1)) begin
        run_d = 1'b0;
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      rst_req <= req_d;
    end
  end

  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !accept && cnt_q > WD_VAL_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8
  req_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == '0 && !run_q));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !accept) |=> $stable(cnt_q));
  // R5
  reload_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt_q != '0 && cnt_q <= WD_VAL_W'(WD_RELOAD_Z)));
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WD_DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WD_DATA_W-1:0] rd_data,
  output logic                 rst_req
);
  logic                 wr_ctrl;
  logic                 accept;
  logic [WD_DATA_W-1:0] ctrl_q;
  logic [WD_VAL_W-1:0]  cnt_q;
  logic                 run_q;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_OFS);

  wdg_keygate u_gate (
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .accept  (accept)
  );

  wdg_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  wdg_downcnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .accept  (accept),
    .ld_val  (wr_data[WD_CNT_W-1:0]),
    .ld_run  (wr_data[WD_CMD_BIT]),
    .cnt_q   (cnt_q),
    .run_q   (run_q),
    .rst_req (rst_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS)      rd_data = ctrl_q;
    else if (rd_addr == STAT_OFS) rd_data = pack_status(cnt_q, run_q);
  end

  // R4
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[WD_CMD_BIT] &&
     wr_data[WD_KEY_MSB:WD_KEY_LSB] != ~ctrl_q[WD_KEY_MSB:WD_KEY_LSB])
    |=> ctrl_q == $past(ctrl_q));
  // R9
  other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CTRL_OFS) |=> ctrl_q == $past(ctrl_q));
endmodule

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          is_req;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  wdg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req)
  );

  function automatic logic [31:0] cw(input logic [6:0] key, input bit cmd, input logic [7:0] cnt);
    return {16'h0, key, cmd, cnt};
  endfunction

  function automatic logic [31:0] st(input int cnt, input bit run);
    return {22'h0, run, 9'(cnt)};
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb.size() > 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        #1;
        act = it.is_req ? {31'h0, rst_req} : rd_data;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = tk;
    @(posedge clk); #1;
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #1; tick_en = 1'b0;
    end
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    sb.push_back('{1'b0, e, tag});
    #1.5;
  endtask

  task automatic chk_req(input bit e, input string tag);
    @(negedge clk);
    sb.push_back('{1'b1, {31'h0, e}, tag});
    #1.5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(8'h40, 32'h0, "R1 control after reset");
    chk_rd(8'h44, 32'h0, "R1 status after reset");
    chk_req(1'b0, "R1 no request after reset");

    wr(8'h40, cw(7'h15, 1, 8'd5));
    chk_rd(8'h40, cw(7'h15, 1, 8'd5), "R2 R3 control stored");
    chk_rd(8'h44, st(5, 1), "R5 R9 status after start");

    tick(2);
    chk_rd(8'h44, st(3, 1), "R7 two ticks");
    repeat (4) @(negedge clk);
    chk_rd(8'h44, st(3, 1), "R7 hold without tick");

    wr(8'h40, cw(7'h15, 1, 8'd100));
    chk_rd(8'h40, cw(7'h15, 1, 8'd5), "R4 same key ignored (control)");
    chk_rd(8'h44, st(3, 1), "R4 same key ignored (count)");

    wr(8'h40, cw(7'h6A, 1, 8'd0));
    chk_rd(8'h44, st(256, 1), "R5 zero loads 256");
    chk_rd(8'h40, cw(7'h6A, 1, 8'd0), "R2 complement stored");

    wr(8'h40, cw(7'h15, 0, 8'd7));
    chk_rd(8'h44, st(7, 0), "R6 stop write");
    tick(3);
    chk_rd(8'h44, st(7, 0), "R6 stopped ignores ticks");

    wr(8'h40, cw(7'h33, 1, 8'd2));
    chk_rd(8'h44, st(2, 1), "R3 any key while disabled");

    tick(2);
    chk_req(1'b1, "R8 request on expiry");
    chk_req(1'b0, "R8 request lasts one cycle");
    chk_rd(8'h44, st(0, 0), "R8 stopped at zero");
    tick(3);
    chk_rd(8'h44, st(0, 0), "R8 stays stopped");
    chk_req(1'b0, "R8 no second request");

    wr(8'h40, cw(7'h11, 1, 8'd4));
    chk_rd(8'h44, st(0, 0), "R8 R4 wrong key after expiry");
    wr(8'h40, cw(7'h4C, 1, 8'd3));
    chk_rd(8'h44, st(3, 1), "R8 restart with complement");

    wr(8'h40, cw(7'h33, 1, 8'd9), 1'b1);
    chk_rd(8'h44, st(9, 1), "R10 write beats tick");

    wr(8'h48, cw(7'h4C, 0, 8'd1));
    chk_rd(8'h40, cw(7'h33, 1, 8'd9), "R9 other offset write ignored");
    chk_rd(8'h44, st(9, 1), "R9 other offset no count change");
    chk_rd(8'h48, 32'h0, "R9 other offset reads zero");

    wait (sb.size() == 0);
    #4;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule